// File: doc/BRIEF.md
# I2C Control Register Slave

This block is a two-wire serial slave that keeps the control settings of a supply-and-signalling controller in four read/write bytes and exposes two read-only status bytes. A host selects one of two bus addresses through a strap pin. It writes a start register index followed by any number of data bytes, and the index steps forward after every byte. To read, the host first writes the index, closes with STOP, and then opens a read transaction. The slave returns consecutive bytes for as long as the host acknowledges them.

The defined control bits are decoded straight onto output pins: output voltage code, tone enable, tone source mode, pulsed current limit mode, and the two recovery-policy bits for overload and overtemperature. The first status byte reports three raw fault inputs. A one-cycle strobe marks every complete transmission of that byte, so that fault latches outside the block can clear on a host read. While the supply-low flag is asserted, the slave ignores the bus completely and holds every register at zero.

The bus is sampled with the system clock through synchronisers, so SCL must be slow compared with that clock.

Top module: `i2cCtlRegSlave`

## Requirements
- R1: The slave acknowledges address 0001000 when `addrSel` is 0 and 0001001 when it is 1. No other address is acknowledged. The eighth bit of the address byte selects the direction, with 1 meaning read.
- R2: In a write, every byte after the address is acknowledged. The first byte loads the register index, and each later byte goes to the index and then advances it. The transfer ends on STOP.
- R3: A read returns the byte at the current index and advances the index. Further bytes follow while the host acknowledges, and a host NACK ends the transfer.
- R4: Index 2 to 5 hold the four control bytes. Reading one returns the last value written with its reserved bits as 0. The kept bits are index 2 [3:0], index 3 [0] and [2], index 4 [2], and index 5 [3] and [6].
- R5: `voltSel` = index 2 [3:0], `toneEnable` = index 3 [0], `extToneMode` = index 3 [2], `pulsedLimit` = index 4 [2], `overloadRestart` = index 5 [3], `thermalRestart` = index 5 [6].
- R6: Index 0 reads {lowSupplyFault, overtempFault, 5'b0, overloadFault} (bit 7 down to bit 0), and index 1 reads 0x00. Writes to both are acknowledged and have no effect.
- R7: The index wraps from 5 to 0, and from 255 to 0. Indices 6 to 255 read 0x00, and writes to them are acknowledged and discarded.
- R8: While `uvFlag` is 1, no byte is acknowledged, SDA is released and all control outputs are 0. After `uvFlag` falls, every control byte reads 0.
- R9: `statusReadStrobe` pulses for exactly one clock cycle after each index-0 byte has been fully shifted out.
- R10: After reset, all control outputs are 0 and `sdaPullLow` is 0.
- R11: Bytes travel MSB first in both directions, and the slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level (wired-AND bus) |
| addrSel | input | 1 | Strap selecting the address LSB |
| uvFlag | input | 1 | Supply-low indication |
| overloadFault | input | 1 | Raw overload condition |
| overtempFault | input | 1 | Raw overtemperature condition |
| lowSupplyFault | input | 1 | Raw low-input-supply condition |
| sdaPullLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| voltSel | output | 4 | Output voltage code |
| toneEnable | output | 1 | Tone enable |
| extToneMode | output | 1 | Tone source mode |
| pulsedLimit | output | 1 | Pulsed current limit mode select |
| overloadRestart | output | 1 | Overload recovery policy |
| thermalRestart | output | 1 | Overtemperature recovery policy |
| statusReadStrobe | output | 1 | One-cycle pulse per status byte sent |

## Verification
Directed transfers write all-ones bytes, so every kept and reserved bit is exercised at once. They also address both strap values with both candidate addresses, which separates address matching from address-pin decoding. Reads that start at index 4 and at 255 cross both wrap points, and asymmetric fault patterns such as 0x81 show whether the status bits land at the right positions. A seeded random loop then mixes writes and reads of random lengths from random start indices, including status and unmapped indices, against a bench model of the register contents and the index. It tracks the expected number of status strobes and watches that the slave's SDA drive never moves during a stable SCL high phase.

// File: rtl/i2cCtlRegPkg.sv
package i2cCtlRegPkg;
  localparam int DATA_REGS   = 4;
  localparam int FIRST_DATA  = 2;
  localparam int LAST_REG    = FIRST_DATA + DATA_REGS - 1;
  localparam int STATUS_MAIN = 0;
  localparam int BYTE_BITS   = 8;

  typedef enum logic [2:0] {
    sIdle, sRxByte, sAckOut, sTxByte, sAckIn
  } busState_e;

  typedef enum logic [1:0] {
    kAddr, kIndex, kData
  } rxKind_e;

  typedef struct packed {
    logic       ptrLoad;
    logic       regWrite;
    logic       txLoad;
    logic       txDone;
    logic [7:0] rxByte;
  } ctlStrobes_t;

  function automatic logic [7:0] keptBits(int idx);
    case (idx)
      0:       keptBits = 8'h0F;
      1:       keptBits = 8'h05;
      2:       keptBits = 8'h04;
      3:       keptBits = 8'h48;
      default: keptBits = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] stepIndex(logic [7:0] p);
    stepIndex = (p == 8'(LAST_REG)) ? 8'd0 : p + 8'd1;
  endfunction
endpackage

// File: rtl/i2cBusCtrl.sv
module i2cBusCtrl
  import i2cCtlRegPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE   = 7'b0001000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        addrSel,
  input  logic        uvFlag,
  input  logic [7:0]  readData,
  output logic        sdaLow,
  output ctlStrobes_t stb
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
      sclD <= sclPipe[SYNC_STAGES-1];
      sdaD <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  logic [6:0] ownAddr;
  assign ownAddr = {ADDR_BASE[6:1], addrSel};

  busState_e        state;
  rxKind_e          kind;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       rxShift, txShift;
  logic             isRead, hostAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= sIdle;
      kind    <= kAddr;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      isRead  <= 1'b0;
      hostAck <= 1'b0;
      sdaLow  <= 1'b0;
      stb     <= '0;
    end else begin
      stb <= '0;
      if (uvFlag) begin
        state  <= sIdle;
        sdaLow <= 1'b0;
      end else if (startDet) begin
        state  <= sRxByte;
        kind   <= kAddr;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (stopDet) begin
        state  <= sIdle;
        sdaLow <= 1'b0;
      end else begin
        case (state)
          sRxByte: begin
            if (sclRise) begin
              rxShift <= {rxShift[6:0], sdaS};
              bitCnt  <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == CNT_W'(BYTE_BITS)) begin
              bitCnt <= '0;
              if (kind == kAddr) begin
                if (rxShift[7:1] == ownAddr) begin
                  isRead <= rxShift[0];
                  sdaLow <= 1'b1;
                  state  <= sAckOut;
                end else begin
                  state <= sIdle;
                end
              end else begin
                sdaLow       <= 1'b1;
                state        <= sAckOut;
                stb.ptrLoad  <= (kind == kIndex);
                stb.regWrite <= (kind == kData);
                stb.rxByte   <= rxShift;
              end
            end
          end
          sAckOut: begin
            if (sclFall) begin
              if (kind == kAddr && isRead) begin
                state      <= sTxByte;
                txShift    <= readData;
                sdaLow     <= ~readData[7];
                stb.txLoad <= 1'b1;
                bitCnt     <= '0;
              end else begin
                sdaLow <= 1'b0;
                state  <= sRxByte;
                kind   <= (kind == kAddr) ? kIndex : kData;
              end
            end
          end
          sTxByte: begin
            if (sclFall) begin
              if (bitCnt == CNT_W'(BYTE_BITS - 1)) begin
                sdaLow     <= 1'b0;
                state      <= sAckIn;
                stb.txDone <= 1'b1;
              end else begin
                sdaLow  <= ~txShift[6];
                txShift <= {txShift[6:0], 1'b0};
                bitCnt  <= bitCnt + 1'b1;
              end
            end
          end
          sAckIn: begin
            if (sclRise) begin
              hostAck <= ~sdaS;
            end else if (sclFall) begin
              if (hostAck) begin
                state      <= sTxByte;
                txShift    <= readData;
                sdaLow     <= ~readData[7];
                stb.txLoad <= 1'b1;
                bitCnt     <= '0;
              end else begin
                state <= sIdle;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: the supply-low flag releases the bus on the next cycle
  assert_uv_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    uvFlag |=> !sdaLow);

  // R3: at most one datapath action per cycle
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ptrLoad, stb.regWrite, stb.txLoad, stb.txDone}));

  // R11: drive changes only once SCL has been seen low
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaLow) && !$past(uvFlag) && !$past(stopDet) && !$past(startDet))
      |-> !sclS);
endmodule

// File: rtl/regFileDp.sv
module regFileDp
  import i2cCtlRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        uvFlag,
  input  ctlStrobes_t stb,
  input  logic        overloadFault,
  input  logic        overtempFault,
  input  logic        lowSupplyFault,
  output logic [7:0]  readData,
  output logic [DATA_REGS*BYTE_BITS-1:0] regsFlat,
  output logic        statusReadStrobe
);
  logic [7:0] ptr;
  logic       txFromStatus;
  logic [7:0] statusMain;

  assign statusMain = {lowSupplyFault, overtempFault, 5'b0, overloadFault};

  for (genvar g = 0; g < DATA_REGS; g++) begin : g_ctl
    localparam logic [7:0] KEEP = keptBits(g);
    logic [7:0] value;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        value <= '0;
      else if (uvFlag)
        value <= '0;
      else if (stb.regWrite && ptr == 8'(FIRST_DATA + g))
        value <= stb.rxByte & KEEP;
    end
    assign regsFlat[g*BYTE_BITS +: BYTE_BITS] = value;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr              <= '0;
      txFromStatus     <= 1'b0;
      statusReadStrobe <= 1'b0;
    end else begin
      statusReadStrobe <= stb.txDone && txFromStatus && !uvFlag;
      if (uvFlag) begin
        ptr          <= '0;
        txFromStatus <= 1'b0;
      end else if (stb.ptrLoad) begin
        ptr <= stb.rxByte;
      end else if (stb.regWrite) begin
        ptr <= stepIndex(ptr);
      end else if (stb.txLoad) begin
        ptr          <= stepIndex(ptr);
        txFromStatus <= (ptr == 8'(STATUS_MAIN));
      end
    end
  end

  always_comb begin
    readData = '0;
    if (ptr == 8'(STATUS_MAIN))
      readData = statusMain;
    for (int i = 0; i < DATA_REGS; i++)
      if (ptr == 8'(FIRST_DATA + i))
        readData = regsFlat[i*BYTE_BITS +: BYTE_BITS];
  end

  // R8: registers are cleared while supply is low
  assert_uv_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    uvFlag |=> (regsFlat == '0));

  // R9: the status strobe never lasts two cycles
  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusReadStrobe |=> !statusReadStrobe);

  // R6/R7: a write outside the control bytes changes nothing
  assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWrite && !uvFlag && (ptr < 8'(FIRST_DATA) || ptr > 8'(LAST_REG)))
      |=> $stable(regsFlat));

  // R7: index wraps from the last register to zero
  assert_index_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txLoad && !uvFlag && ptr == 8'(LAST_REG)) |=> (ptr == 8'd0));
endmodule

// File: rtl/i2cCtlRegSlave.sv
module i2cCtlRegSlave
  import i2cCtlRegPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE   = 7'b0001000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  input  logic       uvFlag,
  input  logic       overloadFault,
  input  logic       overtempFault,
  input  logic       lowSupplyFault,
  output logic       sdaPullLow,
  output logic [3:0] voltSel,
  output logic       toneEnable,
  output logic       extToneMode,
  output logic       pulsedLimit,
  output logic       overloadRestart,
  output logic       thermalRestart,
  output logic       statusReadStrobe
);
  ctlStrobes_t stb;
  logic [7:0]  readData;
  logic [DATA_REGS*BYTE_BITS-1:0] regsFlat;

  i2cBusCtrl #(.SYNC_STAGES(SYNC_STAGES), .ADDR_BASE(ADDR_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrSel(addrSel), .uvFlag(uvFlag), .readData(readData),
    .sdaLow(sdaPullLow), .stb(stb)
  );

  regFileDp uDp (
    .clk(clk), .rstN(rstN), .uvFlag(uvFlag), .stb(stb),
    .overloadFault(overloadFault), .overtempFault(overtempFault),
    .lowSupplyFault(lowSupplyFault), .readData(readData),
    .regsFlat(regsFlat), .statusReadStrobe(statusReadStrobe)
  );

  assign voltSel         = regsFlat[3:0];
  assign toneEnable      = regsFlat[8];
  assign extToneMode     = regsFlat[10];
  assign pulsedLimit     = regsFlat[18];
  assign overloadRestart = regsFlat[27];
  assign thermalRestart  = regsFlat[30];

  logic unusedBits;
  assign unusedBits = ^{regsFlat[7:4], regsFlat[9], regsFlat[15:11],
                        regsFlat[17:16], regsFlat[23:19], regsFlat[26:24],
                        regsFlat[29:28], regsFlat[31]};
endmodule

// File: tb/i2cCtlRegSlave_test.sv
module i2cCtlRegSlave_test;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, scl, sdaM, addrSel, uv, olF, otF, lsF;
  logic sdaLow, toneEn, extMode, pcl, olr, therm, stStb;
  logic [3:0] vsel;
  wire sdaBus = sdaM & ~sdaLow;

  i2cCtlRegSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .addrSel(addrSel),
    .uvFlag(uv), .overloadFault(olF), .overtempFault(otF), .lowSupplyFault(lsF),
    .sdaPullLow(sdaLow), .voltSel(vsel), .toneEnable(toneEn), .extToneMode(extMode),
    .pulsedLimit(pcl), .overloadRestart(olr), .thermalRestart(therm),
    .statusReadStrobe(stStb)
  );

  int nChecks = 0, nFails = 0;
  int stbSeen = 0, stbExp = 0, sdaViol = 0, sclHigh = 0;
  logic sdaLowPrev = 1'b0;
  logic [7:0] mdl [4];
  logic [7:0] wrBuf [8];
  logic [7:0] rdBuf [8];

  always @(posedge clk) begin
    if (stStb) stbSeen++;
    if (scl) sclHigh++; else sclHigh = 0;
    if (rstN && !uv && scl && sclHigh > 3 && sdaLow != sdaLowPrev) sdaViol++;
    sdaLowPrev = sdaLow;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] keep(int i);
    case (i) 0: keep = 8'h0F; 1: keep = 8'h05; 2: keep = 8'h04; 3: keep = 8'h48;
      default: keep = 8'h00; endcase
  endfunction
  function automatic logic [7:0] nxt(logic [7:0] p);
    nxt = (p == 8'd5) ? 8'd0 : p + 8'd1;
  endfunction
  function automatic logic [7:0] expRd(logic [7:0] p);
    if (p == 8'd0) expRd = {lsF, otF, 5'b0, olF};
    else if (p >= 8'd2 && p <= 8'd5) expRd = mdl[p-2];
    else expRd = 8'h00;
  endfunction
  function automatic logic [15:0] expFields();
    expFields = {7'b0, mdl[0][3:0], mdl[1][0], mdl[1][2], mdl[2][2], mdl[3][3], mdl[3][6]};
  endfunction
  function automatic logic [15:0] actFields();
    actFields = {7'b0, vsel, toneEn, extMode, pcl, olr, therm};
  endfunction

  task automatic sendBit(logic b);
    sdaM = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
  endtask
  task automatic recvBit(output logic b);
    sdaM = 1; tick(Q); scl = 1; tick(Q); b = sdaBus; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic i2cStart();
    sdaM = 1; tick(Q); scl = 1; tick(Q); sdaM = 0; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic i2cStop();
    sdaM = 0; tick(Q); scl = 1; tick(Q); sdaM = 1; tick(3*Q);
  endtask
  task automatic wrByte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b); ack = ~b;
  endtask
  task automatic rdByte(logic giveAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); v[i] = b; end
    sendBit(~giveAck);
  endtask

  function automatic logic [6:0] devAddr(); devAddr = {6'b000100, addrSel}; endfunction

  task automatic writeRegs(logic [7:0] idx, int n, output logic allAck);
    logic a; logic [7:0] p;
    allAck = 1;
    i2cStart();
    wrByte({devAddr(), 1'b0}, a); allAck &= a;
    if (a) begin
      wrByte(idx, a); allAck &= a;
      for (int k = 0; k < n; k++) begin wrByte(wrBuf[k], a); allAck &= a; end
    end
    i2cStop();
    if (allAck) begin
      p = idx;
      for (int k = 0; k < n; k++) begin
        if (p >= 8'd2 && p <= 8'd5) mdl[p-2] = wrBuf[k] & keep(int'(p) - 2);
        p = nxt(p);
      end
    end
  endtask

  task automatic readRegs(logic [7:0] idx, int n, string tag);
    logic a; logic [7:0] p;
    i2cStart(); wrByte({devAddr(), 1'b0}, a); wrByte(idx, a); i2cStop();
    i2cStart(); wrByte({devAddr(), 1'b1}, a);
    chk({tag, " R1 read address ack"}, {15'b0, a}, 16'd1);
    for (int k = 0; k < n; k++) rdByte(k != n - 1, rdBuf[k]);
    i2cStop();
    p = idx;
    for (int k = 0; k < n; k++) begin
      if (p == 8'd0) stbExp++;
      chk($sformatf("%s R3 byte %0d idx %0d", tag, k, p), {8'b0, rdBuf[k]}, {8'b0, expRd(p)});
      p = nxt(p);
    end
    chk({tag, " R9 strobe count"}, 16'(stbSeen), 16'(stbExp));
  endtask

  task automatic finishRun();
    chk("R11 sda drive stable while SCL high", 16'(sdaViol), 16'd0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic ok, a;
    void'($urandom(32'd20240611));
    rstN = 0; scl = 1; sdaM = 1; addrSel = 0; uv = 0; olF = 0; otF = 0; lsF = 0;
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    tick(6); rstN = 1; tick(4);

    // R10 reset state
    chk("R10 fields after reset", actFields(), 16'd0);
    chk("R10 sda released after reset", {15'b0, sdaLow}, 16'd0);

    // R2/R5 write all ones to the four control bytes
    for (int k = 0; k < 4; k++) wrBuf[k] = 8'hFF;
    writeRegs(8'd2, 4, ok);
    chk("R2 every write byte acked", {15'b0, ok}, 16'd1);
    chk("R5 fields after all-ones write", actFields(), expFields());
    chk("R5 voltSel all ones", {12'b0, vsel}, 16'h000F);
    readRegs(8'd2, 4, "R4 masked readback");

    // R1 address selection
    i2cStart(); wrByte(8'h12, a); i2cStop();
    chk("R1 0001001 not acked with pin low", {15'b0, a}, 16'd0);
    addrSel = 1; tick(4);
    i2cStart(); wrByte(8'h12, a); i2cStop();
    chk("R1 0001001 acked with pin high", {15'b0, a}, 16'd1);
    i2cStart(); wrByte(8'h10, a); i2cStop();
    chk("R1 0001000 not acked with pin high", {15'b0, a}, 16'd0);
    wrBuf[0] = 8'h05; writeRegs(8'd2, 1, ok);
    chk("R1 write via alternate address", actFields(), expFields());
    addrSel = 0; tick(4);

    // R6 status layout (0x81 asymmetric, MSB first per R11) and ignored writes
    olF = 1; otF = 0; lsF = 1;
    readRegs(8'd0, 2, "R6 status 0x81");
    wrBuf[0] = 8'hAA; wrBuf[1] = 8'hBB; writeRegs(8'd0, 2, ok);
    chk("R6 status write acked", {15'b0, ok}, 16'd1);
    chk("R6 status write no effect on fields", actFields(), expFields());
    olF = 0; otF = 1; lsF = 0;
    readRegs(8'd0, 1, "R6 status 0x40");

    // R7 wrap 5 -> 0 and 255 -> 0, unmapped indices
    readRegs(8'd4, 4, "R7 wrap from index 4");
    readRegs(8'hFF, 2, "R7 wrap from index 255");
    readRegs(8'h10, 1, "R7 unmapped read");
    wrBuf[0] = 8'h3C; wrBuf[1] = 8'hC3; writeRegs(8'hFE, 2, ok);
    chk("R7 unmapped write no effect", actFields(), expFields());
    readRegs(8'd2, 4, "R7 data after unmapped write");

    // R8 undervoltage
    uv = 1; tick(4);
    chk("R8 fields zero under uv", actFields(), 16'd0);
    i2cStart(); wrByte(8'h10, a); i2cStop();
    chk("R8 no ack under uv", {15'b0, a}, 16'd0);
    uv = 0; tick(4);
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    readRegs(8'd2, 4, "R8 data zero after uv");

    // random mix
    for (int it = 0; it < 22; it++) begin
      int n; logic [7:0] idx;
      olF = 1'($urandom); otF = 1'($urandom); lsF = 1'($urandom);
      n = $urandom_range(1, 4);
      idx = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(6, 255)) : 8'($urandom_range(0, 5));
      for (int k = 0; k < n; k++) wrBuf[k] = 8'($urandom);
      writeRegs(idx, n, ok);
      chk($sformatf("R2 random write %0d acked", it), {15'b0, ok}, 16'd1);
      chk($sformatf("R5 random fields %0d", it), actFields(), expFields());
      readRegs(8'($urandom_range(0, 6)), $urandom_range(1, 6), "R4 random read");
    end

    finishRun();
  end
endmodule